// File: doc/BRIEF.md
# RTC Serial Time-Read Port

This block is the slave end of a three-wire read port on a real-time clock. The pins are a chip enable, a serial clock and one bidirectional data line. All three pins are brought into a faster system clock through two-flop synchronizers, and the serial clock edges are detected in that domain. While the enable is high, a read frame opens on the first serial rising edge that samples the data line low. That edge and the next seven rising edges carry control bits, which this block counts but does not decode. On the eighth falling edge a parallel time/date bus is captured into a 52-bit shift register. From then on the pad driver is enabled, and one bit leaves per rising edge.

The captured image is never refreshed during the frame. A seconds carry that arrives mid-frame therefore cannot tear the read-out, and it is reported to the counter logic as a missed tick. Output stops advancing after the sixtieth rising edge and then holds. Dropping the enable ends the frame at any point. A new frame is refused until the enable has stayed low for a programmable number of system cycles.

Top module: `rtc_read_port`

## Requirements
- R1: A frame opens only on a serial rising edge that samples DATA low while CE is high; rising edges that sample DATA high before that opening edge are not counted, so the output driver still stays off after the seventh falling edge that follows the opening edge.
- R2: `sdata_oe_o` is low out of reset, stays low through the eighth rising edge of the frame, and is high after the eighth falling edge.
- R3: The 52 output bits form a word whose bit k is driven after rising edge 9+k (k = 0..51). The word is, from LSB upward: seconds[7:0], minutes[7:0], hours[7:0], week[3:0], day[7:0], month[7:0], year[7:0].
- R4: The time inputs are captured only on the eighth falling edge; changing them later in the frame does not change any output bit.
- R5: After the sixtieth rising edge, `sdata_o` holds year bit 7 for any further rising edges.
- R6: `done_o` pulses for exactly one system cycle per frame that reaches its sixtieth rising edge, and does not pulse for a shorter frame.
- R7: CE low ends the frame: `sdata_oe_o` falls within 5 system cycles, and the next accepted frame starts again from its control bits.
- R8: If CE was low for fewer than RECOVERY_CYCLES synchronized system cycles, the following CE-high period opens no frame, and `sdata_oe_o` stays low.
- R9: A `tick_i` pulse while a frame is open gives one `tick_missed_o` pulse on the next cycle; a tick while CE is low gives none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_i | input | 1 | Chip enable pin, asynchronous |
| sclk_i | input | 1 | Serial clock pin, asynchronous |
| sdata_i | input | 1 | Data pin input path |
| sec_i | input | 8 | Seconds, BCD |
| min_i | input | 8 | Minutes, BCD |
| hour_i | input | 8 | Hours, BCD |
| week_i | input | 4 | Weekday |
| day_i | input | 8 | Day of month, BCD |
| month_i | input | 8 | Month, BCD |
| year_i | input | 8 | Year, BCD |
| tick_i | input | 1 | One-second carry from the counters |
| sdata_o | output | 1 | Data pin output value |
| sdata_oe_o | output | 1 | Data pin output enable |
| done_o | output | 1 | One-cycle pulse at rising edge 60 |
| tick_missed_o | output | 1 | Tick arrived while a frame was open |

## Verification
A wrong edge count moves the whole bit stream by one or more places. This shows at the pin as a mismatch at the first rising edge after the count went astray, and the timing of the driver enable moves with it. A capture that refires late, or a shift register that loses its image, shows at the first bit driven after the time inputs are scrambled mid-frame. A stuck recovery counter or frame state shows up in the next frame as a driver that never turns on, or one that turns on when it should not.

// File: rtl/rtc_read_pkg.sv
package rtc_read_pkg;
  localparam int unsigned CTRL_BITS   = 8;
  localparam int unsigned DATA_BITS   = 52;
  localparam int unsigned FRAME_RISES = CTRL_BITS + DATA_BITS;
  localparam int unsigned CNT_W       = $clog2(FRAME_RISES + 1);

  localparam logic [CNT_W-1:0] CNT_CTRL = CNT_W'(CTRL_BITS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_RISES);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CTRL = 2'd1,
    ST_DATA = 2'd2
  } frame_state_e;
endpackage

// File: rtl/rtc_sync.sv
module rtc_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= RST_VAL[g];
        s2_q <= RST_VAL[g];
      end else begin
        s1_q <= async_i[g];
        s2_q <= s1_q;
      end
    end
    assign sync_o[g] = s2_q;
  end
endmodule

// File: rtl/rtc_frame_ctl.sv
module rtc_frame_ctl
  import rtc_read_pkg::*;
#(
  parameter int unsigned RECOVERY_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_i,
  input  logic sclk_i,
  input  logic sdata_i,
  output logic load_o,
  output logic shift_o,
  output logic oe_o,
  output logic done_o,
  output logic open_o
);
  localparam int unsigned REC_W = $clog2(RECOVERY_CYCLES + 2);
  localparam logic [REC_W-1:0] REC_MAX = REC_W'(RECOVERY_CYCLES);

  frame_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [REC_W-1:0] rec_q;
  logic sclk_q, ce_q, oe_q, done_q;
  logic rise, fall, rec_done, load, shift;

  assign rise     = sclk_i & ~sclk_q;
  assign fall     = ~sclk_i & sclk_q;
  assign rec_done = (rec_q == REC_MAX);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    load    = 1'b0;
    shift   = 1'b0;
    if (!ce_i) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (rec_done && rise && !sdata_i) begin
          state_d = ST_CTRL;
          cnt_d   = CNT_W'(1);
        end
        ST_CTRL: begin
          if (rise && cnt_q < CNT_CTRL) begin
            cnt_d = cnt_q + 1'b1;
          end else if (fall && cnt_q == CNT_CTRL) begin
            load    = 1'b1;
            state_d = ST_DATA;
          end
        end
        ST_DATA: if (rise && cnt_q < CNT_LAST) begin
          shift = 1'b1;
          cnt_d = cnt_q + 1'b1;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sclk_q  <= 1'b0;
      ce_q    <= 1'b0;
      oe_q    <= 1'b0;
      done_q  <= 1'b0;
      rec_q   <= REC_MAX;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sclk_q  <= sclk_i;
      ce_q    <= ce_i;
      done_q  <= shift && (cnt_q == CNT_LAST - 1'b1);
      if (!ce_i)     oe_q <= 1'b0;
      else if (load) oe_q <= 1'b1;
      if (ce_q && !ce_i)            rec_q <= '0;
      else if (!ce_i && !rec_done)  rec_q <= rec_q + 1'b1;
    end
  end

  assign load_o  = load;
  assign shift_o = shift;
  assign oe_o    = oe_q;
  assign done_o  = done_q;
  assign open_o  = (state_q != ST_IDLE);

  a_r2_oe_off_without_ce: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_i |=> !oe_o);
  a_r5_count_saturates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DATA && cnt_q == CNT_LAST && ce_i) |=> cnt_q == CNT_LAST);
  a_r6_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r8_no_open_unrecovered: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !rec_done) |=> state_q == ST_IDLE);
  a_r4_single_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> (state_q == ST_DATA && !load_o));
endmodule

// File: rtl/rtc_shift_out.sv
module rtc_shift_out
  import rtc_read_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic                 shift_i,
  input  logic [DATA_BITS-1:0] snap_i,
  output logic                 dout_o
);
  logic [DATA_BITS-1:0] sh_q;
  logic dout_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      dout_q <= 1'b0;
    end else if (load_i) begin
      sh_q <= snap_i;
    end else if (shift_i) begin
      dout_q <= sh_q[0];
      sh_q   <= sh_q >> 1;
    end
  end

  assign dout_o = dout_q;

  a_r5_hold_without_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> $stable(dout_o));
endmodule

// File: rtl/rtc_read_port.sv
module rtc_read_port
  import rtc_read_pkg::*;
#(
  parameter int unsigned RECOVERY_CYCLES = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ce_i,
  input  logic       sclk_i,
  input  logic       sdata_i,
  input  logic [7:0] sec_i,
  input  logic [7:0] min_i,
  input  logic [7:0] hour_i,
  input  logic [3:0] week_i,
  input  logic [7:0] day_i,
  input  logic [7:0] month_i,
  input  logic [7:0] year_i,
  input  logic       tick_i,
  output logic       sdata_o,
  output logic       sdata_oe_o,
  output logic       done_o,
  output logic       tick_missed_o
);
  logic [2:0] pins_s;
  logic ce_s, sclk_s, sdata_s;
  logic load, shift, frame_open, missed_q;
  logic [DATA_BITS-1:0] snap;

  rtc_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({sdata_i, sclk_i, ce_i}),
    .sync_o  (pins_s)
  );
  assign ce_s    = pins_s[0];
  assign sclk_s  = pins_s[1];
  assign sdata_s = pins_s[2];

  rtc_frame_ctl #(.RECOVERY_CYCLES(RECOVERY_CYCLES)) u_ctl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ce_i    (ce_s),
    .sclk_i  (sclk_s),
    .sdata_i (sdata_s),
    .load_o  (load),
    .shift_o (shift),
    .oe_o    (sdata_oe_o),
    .done_o  (done_o),
    .open_o  (frame_open)
  );

  // shift order: seconds first, LSB first
  assign snap = {year_i, month_i, day_i, week_i, hour_i, min_i, sec_i};

  rtc_shift_out u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .shift_i (shift),
    .snap_i  (snap),
    .dout_o  (sdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) missed_q <= 1'b0;
    else         missed_q <= tick_i && frame_open;
  end
  assign tick_missed_o = missed_q;

  a_r9_tick_flagged: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && frame_open) |=> tick_missed_o);
  a_r9_no_flag_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frame_open) |=> !tick_missed_o);
endmodule

// File: tb/rtc_read_port_test.sv
module rtc_read_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;
  localparam int REC = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce = 1'b0, sclk = 1'b0, sdata = 1'b1, tick = 1'b0;
  logic [7:0] sec, mnt, hour, day, month, year;
  logic [3:0] week;
  logic sdata_o, oe, done, missed;

  int total = 0, bad = 0, done_seen = 0, missed_seen = 0;
  bit finished = 0;
  logic [1:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_read_port #(.RECOVERY_CYCLES(REC)) uut (
    .clk_i(clk), .rst_ni(rst_n), .ce_i(ce), .sclk_i(sclk), .sdata_i(sdata),
    .sec_i(sec), .min_i(mnt), .hour_i(hour), .week_i(week), .day_i(day),
    .month_i(month), .year_i(year), .tick_i(tick),
    .sdata_o(sdata_o), .sdata_oe_o(oe), .done_o(done), .tick_missed_o(missed)
  );

  always @(posedge clk) begin
    if (done)   done_seen++;
    if (missed) missed_seen++;
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // monitor: compare one expected bit per serial falling edge
  always @(negedge sclk) begin
    if (exp_q.size() > 0) begin
      logic [1:0] it;
      it = exp_q.pop_front();
      check(sdata_o === it[0], it[1] ? "R5" : "R3", int'(sdata_o), int'(it[0]));
    end
  end

  task automatic set_time(input logic [51:0] v);
    sec = v[7:0]; mnt = v[15:8]; hour = v[23:16]; week = v[27:24];
    day = v[35:28]; month = v[43:36]; year = v[51:44];
  endtask

  task automatic half_wait();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic run_frame(input logic [51:0] snap, input int pre, input int n,
                           input bit accept, input int tick_at, input int low_cyc);
    set_time(snap);
    done_seen = 0; missed_seen = 0;
    ce = 1'b1; sdata = 1'b1;
    half_wait(); half_wait();
    for (int p = 0; p < pre; p++) begin
      sdata = 1'b1; sclk = 1'b1; half_wait(); sclk = 1'b0; half_wait();
    end
    for (int i = 1; i <= n; i++) begin
      if (i <= 8) sdata = (i == 1) ? 1'b0 : i[0];
      else        sdata = 1'b1;
      sclk = 1'b1;
      half_wait();
      if (accept && i >= 9)
        exp_q.push_back({i > 60, (i > 60) ? snap[51] : snap[i-9]});
      if (i == 8) check(oe == 1'b0, "R2", int'(oe), 0);
      if (i == 12) set_time(~snap); // R4: scramble after capture
      if (i == tick_at) begin
        tick = 1'b1; @(negedge clk); tick = 1'b0;
      end
      sclk = 1'b0;
      half_wait();
      if (i == 7) check(oe == 1'b0, "R1", int'(oe), 0);
      if (i == 8) check(oe == accept, accept ? "R2" : "R8", int'(oe), int'(accept));
    end
    if (accept) check(done_seen == ((n >= 60) ? 1 : 0), "R6", done_seen, (n >= 60) ? 1 : 0);
    if (tick_at > 0) check(missed_seen == 1, "R9", missed_seen, 1);
    ce = 1'b0;
    repeat (low_cyc) @(negedge clk);
    check(oe == 1'b0, "R7", int'(oe), 0);
  endtask

  initial begin
    set_time('0);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(oe == 1'b0, "R2", int'(oe), 0);
    check(done == 1'b0, "R6", int'(done), 0);
    check(missed == 1'b0, "R9", int'(missed), 0);

    run_frame(52'h9_3412_5_2359_47, 0, 64, 1'b1, 20, 40);

    missed_seen = 0;
    tick = 1'b1; @(negedge clk); tick = 1'b0;
    repeat (3) @(negedge clk);
    check(missed_seen == 0, "R9", missed_seen, 0);

    // R1: three ignored rises with DATA high, then short recovery
    run_frame(52'hA_5C3E_1_0F0F_F0, 3, 60, 1'b1, 0, 5);
    // R8: CE was low too briefly
    run_frame(52'h1_2345_6_789A_BC, 0, 12, 1'b0, 0, 40);
    // R7: abort after 36 rises (second..week only)
    run_frame(52'hF_EDCB_A_9876_54, 0, 36, 1'b1, 0, 40);
    check(done_seen == 0, "R7", done_seen, 0);
    // R7: fresh frame after abort
    run_frame(52'h3_C0FF_E_1357_9B, 0, 61, 1'b1, 0, 40);

    check(exp_q.size() == 0, "R3", exp_q.size(), 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule